// File: doc/BRIEF.md
# Clock Control Register Bank

This block is a bank of 32-bit words that hold clock-tree settings for a chip. It holds nine PLL control words, three bus-divider words, a DRAM configuration word, a memory-bus word, two PLL settle-time words and a set of per-PLL bias and tuning words. Software reaches the bank through a plain word bus made of a read strobe, a write strobe, a byte address, write data and registered read data. The bank only stores settings. It does not generate or gate any clock.

Two word classes change the data on its way in. When a PLL control word is written with its enable bit set, the stored word also has its lock flag set, so software that waits on the flag sees it at once. On the DRAM configuration word, the update-request bit is always cleared before the word is stored. The bank decodes byte offsets below 0x308. An access at or above that offset is rejected, and the bank raises a one-cycle error flag.

A small access state machine tracks what the bus did on each edge. Its states are:
- `ST_IDLE`: no access.
- `ST_READ`: an in-range read.
- `ST_WRITE`: an in-range write.
- `ST_REJECT`: an access at or above 0x308.

It has these transitions on every clock edge, from any state:
- A write strobe with an in-range address goes to `ST_WRITE`. An out-of-range address goes to `ST_REJECT`.
- Otherwise, a read strobe with an in-range address goes to `ST_READ`. An out-of-range address goes to `ST_REJECT`.
- Otherwise the machine goes to `ST_IDLE`.
- A synchronous reset forces `ST_IDLE`.

Top module: `ccr_bank`

## Requirements
- R1: Every access is a full 32-bit word. The word index is `addr >> 2`, so address bits 1:0 are ignored for both reads and writes.
- R2: Reset is synchronous and active high. It sets `rdata` to 0 and `err` to 0. Words 0x000 and 0x020 reset to 0x00001000. Words 0x028 and 0x044 reset to 0x00041811. Words 0x010, 0x018, 0x038 and 0x048 reset to 0x03006207. Word 0x008 resets to 0x00035514. Word 0x050 resets to 0x00010000, 0x054 to 0x00001010 and 0x058 to 0x01000000. Word 0x0FC resets to 0x80000000. Words 0x200 and 0x204 reset to 0x000000FF. Word 0x220 resets to 0x08100200 and 0x230 to 0x81104000. Words 0x234 and 0x244 reset to 0x10100010. Words 0x224, 0x228, 0x22C, 0x23C and 0x248 reset to 0x10100000. Word 0x250 resets to 0x0A101000 and 0x260 to 0x14880000. Every other word below 0x308, including 0x0F4, resets to 0.
- R3: The PLL control words are at 0x000, 0x008, 0x010, 0x018, 0x020, 0x028, 0x038, 0x044 and 0x048. A write to one of them with bit 31 set stores bit 28 as 1, whatever value was written to bit 28. With bit 31 clear, the word is stored exactly as written.
- R4: A write to word 0x0F4 stores bit 16 as 0. All its other bits are stored as written.
- R5: A read at a byte address of 0x308 or above returns 0 in `rdata`.
- R6: A write at 0x308 or above changes no word and does not change `rdata`. Any access at 0x308 or above drives `err` high for exactly the cycle after that access. In-range accesses and idle cycles leave `err` low.
- R7: `rdata` is registered. It shows the addressed word in the cycle after a read strobe, and it keeps its value in every cycle that has no read.
- R8: Every other word below 0x308 stores the written value unchanged and reads it back. This includes words that have no named function.
- R9: When `wr_en` and `rd_en` are both high, only the write takes place, and `rdata` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | input | 1 | Read strobe for this cycle |
| wr_en | input | 1 | Write strobe for this cycle, wins over `rd_en` |
| addr | input | 12 | Byte address, bits 1:0 ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| err | output | 1 | One-cycle flag after an out-of-range access |

## Verification
The assertions assume that the strobes and the address are driven to known values in every cycle after reset. The lock and update-bit read-back properties only cover a read of the same word issued in the cycle right after the write. The bench drives all inputs on the falling edge, so they are always defined and stable around the rising edge. It makes both back-to-back read-backs and sweeps with other accesses in between. It asserts both strobes together in only one case, which is the deliberate check of write precedence.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    localparam int unsigned CCR_DW = 32;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_REJECT = 2'd3
    } ccr_state_e;

    // Constant loaded into a word on reset, keyed by word index.
    function automatic logic [CCR_DW-1:0] ccr_reset_word(input int unsigned widx);
        logic [CCR_DW-1:0] v;
        case (widx << 2)
            32'h000, 32'h020:                 v = 32'h0000_1000;
            32'h008:                          v = 32'h0003_5514;
            32'h010, 32'h018,
            32'h038, 32'h048:                 v = 32'h0300_6207;
            32'h028, 32'h044:                 v = 32'h0004_1811;
            32'h050:                          v = 32'h0001_0000;
            32'h054:                          v = 32'h0000_1010;
            32'h058:                          v = 32'h0100_0000;
            32'h0FC:                          v = 32'h8000_0000;
            32'h200, 32'h204:                 v = 32'h0000_00FF;
            32'h220:                          v = 32'h0810_0200;
            32'h230:                          v = 32'h8110_4000;
            32'h234, 32'h244:                 v = 32'h1010_0010;
            32'h224, 32'h228, 32'h22C,
            32'h23C, 32'h248:                 v = 32'h1010_0000;
            32'h250:                          v = 32'h0A10_1000;
            32'h260:                          v = 32'h1488_0000;
            default:                          v = '0;
        endcase
        return v;
    endfunction

    // True for the words that carry a PLL enable / lock pair.
    function automatic logic ccr_is_pll(input int unsigned widx);
        logic hit;
        case (widx << 2)
            32'h000, 32'h008, 32'h010, 32'h018, 32'h020,
            32'h028, 32'h038, 32'h044, 32'h048: hit = 1'b1;
            default:                            hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/ccr_decode.sv
module ccr_decode #(
    parameter int unsigned ADDR_W       = 12,
    parameter int unsigned WINDOW_BYTES = 32'h308,
    parameter int unsigned DRAM_OFF     = 32'h0F4,
    localparam int unsigned IDX_W       = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [IDX_W-1:0]  widx_o,
    output logic              in_range_o,
    output logic              pll_hit_o,
    output logic              dram_hit_o
);
    import ccr_pkg::*;

    localparam logic [ADDR_W:0] LIMIT    = (ADDR_W+1)'(WINDOW_BYTES);
    localparam logic [IDX_W-1:0] DRAM_IX = IDX_W'(DRAM_OFF >> 2);

    logic [1:0] unused_byte_lane;

    assign unused_byte_lane = addr_i[1:0];
    assign widx_o     = addr_i[ADDR_W-1:2];
    assign in_range_o = ({1'b0, addr_i} < LIMIT);
    assign pll_hit_o  = in_range_o && ccr_is_pll(32'(widx_o));
    assign dram_hit_o = in_range_o && (widx_o == DRAM_IX);

endmodule

// File: rtl/ccr_wshape.sv
module ccr_wshape #(
    parameter int unsigned DW       = 32,
    parameter int unsigned EN_BIT   = 31,
    parameter int unsigned LOCK_BIT = 28,
    parameter int unsigned UPD_BIT  = 16
) (
    input  logic [DW-1:0] wdata_i,
    input  logic          pll_hit_i,
    input  logic          dram_hit_i,
    output logic [DW-1:0] wval_o
);
    always_comb begin
        wval_o = wdata_i;
        if (pll_hit_i && wdata_i[EN_BIT]) begin
            wval_o[LOCK_BIT] = 1'b1;
        end
        if (dram_hit_i) begin
            wval_o[UPD_BIT] = 1'b0;
        end
    end

endmodule

// File: rtl/ccr_store.sv
module ccr_store #(
    parameter int unsigned DW     = 32,
    parameter int unsigned NWORDS = 194,
    parameter int unsigned IDX_W  = 10,
    localparam int unsigned SEL_W = $clog2(NWORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [IDX_W-1:0] widx_i,
    input  logic [DW-1:0]    wval_i,
    output logic [DW-1:0]    rd_word_o
);
    import ccr_pkg::*;

    logic [DW-1:0] words [NWORDS];

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        logic [DW-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= DW'(ccr_reset_word(g));
            end else if (we_i && (widx_i == IDX_W'(g))) begin
                word_q <= wval_i;
            end
        end
        assign words[g] = word_q;
    end

    always_comb begin
        rd_word_o = '0;
        if (32'(widx_i) < NWORDS) begin
            rd_word_o = words[widx_i[SEL_W-1:0]];
        end
    end

endmodule

// File: rtl/ccr_fsm.sv
module ccr_fsm #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en_i,
    input  logic          wr_en_i,
    input  logic          in_range_i,
    input  logic [DW-1:0] rd_word_i,
    output logic          store_we_o,
    output logic [DW-1:0] rdata_o,
    output logic          err_o
);
    import ccr_pkg::*;

    ccr_state_e state_q, state_d;

    // Next state: a write wins over a read; the range decides accept or reject.
    always_comb begin
        if (wr_en_i) begin
            state_d = in_range_i ? ST_WRITE : ST_REJECT;
        end else if (rd_en_i) begin
            state_d = in_range_i ? ST_READ : ST_REJECT;
        end else begin
            state_d = ST_IDLE;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: read data is loaded on the edge that accepts the access.
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o <= '0;
        end else begin
            unique case (state_d)
                ST_READ:   rdata_o <= rd_word_i;
                ST_REJECT: if (!wr_en_i) rdata_o <= '0;
                ST_WRITE,
                ST_IDLE:   rdata_o <= rdata_o;
            endcase
        end
    end

    assign store_we_o = (state_d == ST_WRITE);
    assign err_o      = (state_q == ST_REJECT);

    assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(rd_en_i && !wr_en_i) |=> $stable(rdata_o));

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && wr_en_i) |=> $stable(rdata_o));

    assert_err_after_reject_R6: assert property (@(posedge clk) disable iff (rst)
        ((rd_en_i || wr_en_i) && !in_range_i) |=> err_o);

    assert_err_only_on_reject_R6: assert property (@(posedge clk) disable iff (rst)
        ((rd_en_i || wr_en_i) && in_range_i) |=> !err_o);

endmodule

// File: rtl/ccr_bank.sv
module ccr_bank #(
    parameter int unsigned ADDR_W       = 12,
    parameter int unsigned WINDOW_BYTES = 32'h308,
    parameter int unsigned DRAM_OFF     = 32'h0F4,
    parameter int unsigned EN_BIT       = 31,
    parameter int unsigned LOCK_BIT     = 28,
    parameter int unsigned UPD_BIT      = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rd_en,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [ccr_pkg::CCR_DW-1:0]  wdata,
    output logic [ccr_pkg::CCR_DW-1:0]  rdata,
    output logic                        err
);
    import ccr_pkg::*;

    localparam int unsigned DW     = CCR_DW;
    localparam int unsigned NWORDS = WINDOW_BYTES / 4;
    localparam int unsigned IDX_W  = ADDR_W - 2;

    logic [IDX_W-1:0] widx;
    logic             in_range, pll_hit, dram_hit, store_we;
    logic [DW-1:0]    wval, rd_word;

    ccr_decode #(
        .ADDR_W(ADDR_W), .WINDOW_BYTES(WINDOW_BYTES), .DRAM_OFF(DRAM_OFF)
    ) i_decode (
        .addr_i(addr), .widx_o(widx), .in_range_o(in_range),
        .pll_hit_o(pll_hit), .dram_hit_o(dram_hit)
    );

    ccr_wshape #(
        .DW(DW), .EN_BIT(EN_BIT), .LOCK_BIT(LOCK_BIT), .UPD_BIT(UPD_BIT)
    ) i_wshape (
        .wdata_i(wdata), .pll_hit_i(pll_hit), .dram_hit_i(dram_hit), .wval_o(wval)
    );

    ccr_store #(
        .DW(DW), .NWORDS(NWORDS), .IDX_W(IDX_W)
    ) i_store (
        .clk(clk), .rst(rst), .we_i(store_we), .widx_i(widx),
        .wval_i(wval), .rd_word_o(rd_word)
    );

    ccr_fsm #(
        .DW(DW)
    ) i_fsm (
        .clk(clk), .rst(rst), .rd_en_i(rd_en), .wr_en_i(wr_en),
        .in_range_i(in_range), .rd_word_i(rd_word), .store_we_o(store_we),
        .rdata_o(rdata), .err_o(err)
    );

    // Tracking of the previous write, used only by the read-back properties.
    logic             chk_pll_en_q, chk_dram_q;
    logic [IDX_W-1:0] chk_widx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_pll_en_q <= 1'b0;
            chk_dram_q   <= 1'b0;
            chk_widx_q   <= '0;
        end else begin
            chk_pll_en_q <= wr_en && pll_hit && wdata[EN_BIT];
            chk_dram_q   <= wr_en && dram_hit;
            chk_widx_q   <= widx;
        end
    end

    assert_lock_readback_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && chk_pll_en_q && widx == chk_widx_q) |=> rdata[LOCK_BIT]);

    assert_update_readback_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && chk_dram_q && widx == chk_widx_q) |=> !rdata[UPD_BIT]);

    assert_oor_read_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && !in_range) |=> (rdata == '0));

    always_comb begin
        if (!rst && store_we) begin
            assert_no_store_oor_R6: assert (in_range);
        end
    end

endmodule

// File: tb/test_ccr_bank.sv
`timescale 1ns/1ps
module test_ccr_bank;

    localparam int NW = 194;
    localparam time TCK = 20ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model [NW];

    always #(TCK/2) clk = ~clk;

    ccr_bank i_ccr_bank (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .err(err)
    );

    function automatic logic [31:0] exp_reset(input int off);
        case (off)
            'h000, 'h020: return 32'h00001000;
            'h008: return 32'h00035514;
            'h010, 'h018, 'h038, 'h048: return 32'h03006207;
            'h028, 'h044: return 32'h00041811;
            'h050: return 32'h00010000;
            'h054: return 32'h00001010;
            'h058: return 32'h01000000;
            'h0FC: return 32'h80000000;
            'h200, 'h204: return 32'h000000FF;
            'h220: return 32'h08100200;
            'h230: return 32'h81104000;
            'h234, 'h244: return 32'h10100010;
            'h224, 'h228, 'h22C, 'h23C, 'h248: return 32'h10100000;
            'h250: return 32'h0A101000;
            'h260: return 32'h14880000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic bit is_pll(input int off);
        return off inside {'h000, 'h008, 'h010, 'h018, 'h020, 'h028, 'h038, 'h044, 'h048};
    endfunction

    function automatic logic [31:0] shaped(input int off, input logic [31:0] v);
        logic [31:0] r = v;
        if (is_pll(off) && r[31]) r[28] = 1'b1;
        if (off == 'h0F4) r[16] = 1'b0;
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic e);
        addr = a; rd_en = 1'b1; wr_en = 1'b0;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
        d = rdata; e = err;
    endtask

    task automatic sweep_read(input string req);
        logic [31:0] d;
        logic e;
        for (int i = 0; i < NW; i++) begin
            bus_read(12'(i*4), d, e);
            check(d == model[i], req, d, model[i]);
            check(e == 1'b0, "R6 in-range no err", 32'(e), 32'h0);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NW; i++) model[i] = exp_reset(i*4);
    endtask

    initial begin
        #(TCK * 200000);
        fails++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d, hold, v;
        logic e;
        @(negedge clk);
        do_reset();

        // R2: reset state of the outputs
        check(rdata == 32'h0, "R2 rdata reset", rdata, 32'h0);
        check(err == 1'b0, "R2 err reset", 32'(err), 32'h0);
        // R2 / R7: every word's reset constant
        sweep_read("R2 reset value");

        // R5 / R6: reads out of range give zero and a one-cycle err
        foreach (v[k]) ; // no-op placeholder-free loop guard
        for (int k = 0; k < 5; k++) begin
            logic [11:0] oa;
            oa = (k == 0) ? 12'h308 : (k == 1) ? 12'h30C : (k == 2) ? 12'h800 : (k == 3) ? 12'hFFC : 12'h30B;
            bus_read(12'h054, d, e);
            bus_read(oa, d, e);
            check(d == 32'h0, "R5 oor read zero", d, 32'h0);
            check(e == 1'b1, "R6 err after oor read", 32'(e), 32'h1);
            @(negedge clk);
            check(err == 1'b0, "R6 err one cycle", 32'(err), 32'h0);
        end

        // R1: low address bits ignored on read
        bus_read(12'h029, d, e);
        check(d == 32'h00041811, "R1 misaligned read", d, 32'h00041811);
        bus_read(12'h0FE, d, e);
        check(d == 32'h80000000, "R1 misaligned read", d, 32'h80000000);

        // R3 / R4 / R8: two write passes with complementary patterns
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < NW; i++) begin
                v = (32'(i) * 32'h9E3779B1) ^ (k == 1 ? 32'hFFFFFFFF : 32'h0);
                bus_write(12'(i*4), v);
                model[i] = shaped(i*4, v);
            end
            sweep_read(k == 0 ? "R8 R3 R4 readback pass0" : "R8 R3 R4 readback pass1");
        end

        // R3: enable set with lock written clear, back-to-back read
        bus_write(12'h038, 32'h8000_0123);
        bus_read(12'h038, d, e);
        check(d == 32'h9000_0123, "R3 lock forced", d, 32'h9000_0123);
        model['h038/4] = d;
        // R3: enable clear, stored as written
        bus_write(12'h044, 32'h1234_5678 & 32'h6FFF_FFFF);
        bus_read(12'h044, d, e);
        check(d == 32'h0234_5678, "R3 no enable as written", d, 32'h0234_5678);
        model['h044/4] = d;
        // R4: update bit set on write, misaligned address (R1)
        bus_write(12'h0F7, 32'hFFFF_FFFF);
        bus_read(12'h0F4, d, e);
        check(d == 32'hFFFE_FFFF, "R4 R1 update bit stripped", d, 32'hFFFE_FFFF);
        model['h0F4/4] = d;

        // R6: out-of-range writes change nothing and leave rdata alone
        bus_read(12'h200, hold, e);
        bus_write(12'h308, 32'hDEAD_BEEF);
        check(err == 1'b1, "R6 err after oor write", 32'(err), 32'h1);
        check(rdata == hold, "R6 oor write keeps rdata", rdata, hold);
        bus_write(12'hFFC, 32'hCAFE_F00D);
        bus_write(12'h400, 32'h0);
        @(negedge clk);
        check(err == 1'b0, "R6 err drops", 32'(err), 32'h0);
        sweep_read("R6 no change after oor writes");

        // R7: rdata holds across idle cycles
        bus_read(12'h054, hold, e);
        repeat (3) @(negedge clk);
        check(rdata == hold, "R7 rdata hold", rdata, hold);

        // R9: both strobes, write wins and rdata stays
        addr = 12'h058; wdata = 32'h0BAD_CAFE; wr_en = 1'b1; rd_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check(rdata == hold, "R9 rdata unchanged", rdata, hold);
        model['h058/4] = 32'h0BAD_CAFE;
        bus_read(12'h058, d, e);
        check(d == 32'h0BAD_CAFE, "R9 write took place", d, 32'h0BAD_CAFE);

        // R2: reset reloads constants after writes
        do_reset();
        check(rdata == 32'h0, "R2 rdata after re-reset", rdata, 32'h0);
        sweep_read("R2 reset value after writes");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule